// File: doc/BRIEF.md
# Scanline Compare Interrupt Unit

This block counts the lines a picture renderer draws and interrupts the CPU when the count reaches a line number that software has programmed. A one-cycle line pulse comes in with the number of the line just starting. A pulse carrying the frame-end line number (240 by default) restarts the count at zero and marks the unit as inside a frame. Each later pulse compares the running count with the target and then advances the count. The count stops at 240 and waits for the next frame-end pulse.

Software uses two byte-wide registers. One holds the target line. The other holds the interrupt enable when written and returns the status byte when read. The status byte carries a pending flag, set when the count matches, and an in-frame flag. A normal read of status acknowledges the interrupt. A debug read returns the same byte and changes nothing. Any register write also drops the interrupt line.

Top module: `scl_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0, the status byte reads 0x00, the target is 0, the enable is 0 and the line count is 0.
- R2: `cpu_sel`=0 selects the 8-bit target register, written from `cpu_wdata`. `cpu_sel`=1 selects control/status. A write there takes the enable from `cpu_wdata` bit 7. A read there returns the status byte: bit 7 is pending, bit 6 is in-frame, bits 5..0 are 0. Reads with `cpu_sel`=0 return 0x00.
- R3: A line pulse whose `line_num` equals 240 sets the count to 0 and the status to 0x40 (in-frame set, pending clear) from the next cycle.
- R4: A line pulse with any other `line_num`, while the count is below 240, sets pending if the count equals the target and then adds one to the count. The first such pulse after a frame-end pulse therefore compares count 0.
- R5: A matching pulse asserts `irq` from the next cycle only when the enable is 1. Pending is set whether or not the enable is 1.
- R6: The pulse that brings the count to 240 clears the whole status byte to 0x00. From then on the count stays at 240 and later pulses other than 240 set nothing, whatever the target.
- R7: A non-debug read of status (`cpu_rd`=1, `cpu_sel`=1, `cpu_dbg`=0) returns the byte as it was before the read. From the next cycle pending is clear, in-frame is unchanged and `irq` is 0.
- R8: A write to either register drives `irq` to 0 from the next cycle and leaves the status byte unchanged.
- R9: A read with `cpu_dbg`=1 returns the status byte and leaves pending, in-frame and `irq` unchanged.
- R10: When a match happens in the same cycle as an acknowledging read or a register write, the match wins: pending and (if enabled) `irq` are 1 afterwards, and the read returns the byte as it was before the match.
- R11: With target 239 and the enable set, the pulse that brings the count to 240 asserts `irq`, and the status byte reads 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | 8 | Number of the line that is starting, valid with `line_pulse` |
| cpu_sel | input | 1 | Register select: 0 target, 1 control/status |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_dbg | input | 1 | Marks a read as inspection with no side effects |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational while `cpu_rd` is high |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that `line_pulse` is a single-cycle strobe with a stable `line_num`, and that `cpu_rd` and `cpu_wr` are never high in the same cycle. They also assume that each read or write lasts exactly one cycle, so each one counts as a single access. The bench drives every strobe for one cycle from the falling edge and never overlaps a read with a write. It keeps line numbers below 240 except at frame end. It overlaps a register access with a line pulse only in the scenario written for the priority rule.

// File: rtl/scl_pkg.sv
// Package scl_pkg
// Shared constants and the flag record for the scanline compare unit.
// Assumes an 8-bit CPU data bus; the status bit positions are fixed.
package scl_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned PEND_BIT = 7;
    localparam int unsigned INFR_BIT = 6;
    localparam int unsigned EN_BIT   = 7;

    typedef struct packed {
        logic pend;
        logic inframe;
    } scl_flags_t;
endpackage

// File: rtl/scl_line_ctr.sv
// Module scl_line_ctr
// Keeps the line count for a frame. It clears the count on the frame-end
// pulse, compares and advances it on the other pulses, and holds it at
// LAST_LINE. Assumes line_pulse lasts one cycle and line_num is steady with it.
module scl_line_ctr #(
    parameter int unsigned LINE_W    = 8,
    parameter int unsigned LAST_LINE = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] target,
    output logic              frame_end,
    output logic              hit,
    output logic              reach
);
    localparam logic [LINE_W-1:0] LAST_V = LINE_W'(LAST_LINE);
    localparam logic [LINE_W-1:0] PRE_V  = LINE_W'(LAST_LINE - 1);

    logic [LINE_W-1:0] count_q;
    logic              active;

    // Decode the kind of pulse for this cycle
    always_comb begin
        frame_end = line_pulse && (line_num == LAST_V);
        active    = line_pulse && !frame_end && (count_q < LAST_V);
        hit       = active && (count_q == target);
        reach     = active && (count_q == PRE_V);
    end

    // Count register: clear at frame end, step on active pulses
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (frame_end)  count_q <= '0;
        else if (active)     count_q <= count_q + 1'b1;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST_V);
    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == LAST_V && !frame_end) |=> count_q == LAST_V);
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/scl_status_flags.sv
// Module scl_status_flags
// Holds the pending and in-frame flags and the interrupt line. It applies
// acknowledge and write clears first and then match sets, so a same-cycle
// match wins. Frame start and frame end override both.
module scl_status_flags
    import scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_end,
    input  logic       hit,
    input  logic       reach,
    input  logic       ack,
    input  logic       wr_any,
    input  logic       enable,
    output scl_flags_t flags,
    output logic       irq
);
    scl_flags_t flags_d;
    logic       irq_d;

    // Next-state for the flags by priority
    always_comb begin
        flags_d = flags;
        if (ack) flags_d.pend = 1'b0;
        if (hit) flags_d.pend = 1'b1;
        if (reach) begin
            flags_d.pend    = 1'b0;
            flags_d.inframe = 1'b0;
        end
        if (frame_end) begin
            flags_d.pend    = 1'b0;
            flags_d.inframe = 1'b1;
        end
    end

    // Next-state for the interrupt line
    always_comb begin
        irq_d = irq;
        if (ack || wr_any) irq_d = 1'b0;
        if (hit && enable) irq_d = 1'b1;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_d;
            irq   <= irq_d;
        end
    end

    // R3
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> flags.inframe && !flags.pend);
    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit && enable));
    // R6
    end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reach |=> flags == '0);
endmodule

// File: rtl/scl_irq_unit.sv
// Module scl_irq_unit
// Top of the scanline compare interrupt unit. It holds the target and enable
// registers, decodes CPU accesses and drives read data. Assumes LINE_W <= 8,
// one-cycle strobes, and never a read and a write in the same cycle.
module scl_irq_unit
    import scl_pkg::*;
#(
    parameter int unsigned LINE_W    = 8,
    parameter int unsigned LAST_LINE = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_dbg,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq
);
    logic [LINE_W-1:0] target_q;
    logic              enable_q;
    logic              frame_end, hit, reach, ack;
    scl_flags_t        flags;
    logic [DATA_W-1:0] status;

    // Target and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            enable_q <= 1'b0;
        end else if (cpu_wr) begin
            if (cpu_sel) enable_q <= cpu_wdata[EN_BIT];
            else         target_q <= cpu_wdata[LINE_W-1:0];
        end
    end

    // Access decode and status byte assembly
    always_comb begin
        ack                = cpu_rd && cpu_sel && !cpu_dbg;
        status             = '0;
        status[PEND_BIT]   = flags.pend;
        status[INFR_BIT]   = flags.inframe;
        cpu_rdata          = (cpu_rd && cpu_sel) ? status : '0;
    end

    scl_line_ctr #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pulse (line_pulse),
        .line_num   (line_num),
        .target     (target_q),
        .frame_end  (frame_end),
        .hit        (hit),
        .reach      (reach)
    );

    scl_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .hit       (hit),
        .reach     (reach),
        .ack       (ack),
        .wr_any    (cpu_wr),
        .enable    (enable_q),
        .flags     (flags),
        .irq       (irq)
    );

    // R8
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !line_pulse) |=> !irq);
    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel && !cpu_dbg && !line_pulse) |=> (!irq && !flags.pend && $stable(flags.inframe)));
    // R9
    dbg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_dbg && !cpu_wr && !line_pulse) |=> ($stable(flags) && $stable(irq)));
    // R5
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enable_q));
endmodule

// File: tb/sim_scl_irq_unit.sv
module sim_scl_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_pulse = 1'b0;
    logic [7:0] line_num = '0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_dbg = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    scl_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .line_num(line_num),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_dbg(cpu_dbg),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one cycle with the given strobes, sampled before the edge
    task automatic cyc(input logic p, input logic [7:0] ln, input logic rd, input logic wr,
                       input logic sel, input logic dbg, input logic [7:0] wd,
                       output logic [7:0] rdv);
        @(negedge clk);
        line_pulse = p; line_num = ln; cpu_rd = rd; cpu_wr = wr;
        cpu_sel = sel; cpu_dbg = dbg; cpu_wdata = wd;
        #1 rdv = cpu_rdata;
        @(negedge clk);
        line_pulse = 0; cpu_rd = 0; cpu_wr = 0; cpu_dbg = 0;
    endtask

    task automatic pulse(input logic [7:0] ln);
        logic [7:0] d;
        cyc(1, ln, 0, 0, 0, 0, 8'h00, d);
    endtask
    task automatic wr(input logic sel, input logic [7:0] v);
        logic [7:0] d;
        cyc(0, 8'h00, 0, 1, sel, 0, v, d);
    endtask
    task automatic rd(input logic sel, input logic dbg, output logic [7:0] v);
        cyc(0, 8'h00, 1, 0, sel, dbg, 8'h00, v);
    endtask
    task automatic peek(output logic [7:0] v);
        rd(1, 1, v);
    endtask
    task automatic lines(input int n);
        for (int i = 0; i < n; i++) pulse(8'(i));
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq", {7'b0, irq}, 8'h00);
        peek(v); chk("R1 status", v, 8'h00);
        rd(0, 0, v); chk("R2 target read", v, 8'h00);
        // target 0 and count 0 after reset: first non-frame pulse matches, enable off
        pulse(8'd3); peek(v); chk("R1 count/target zero", v, 8'h80);
        chk("R1 enable off", {7'b0, irq}, 8'h00);
        rd(1, 0, v);
    endtask

    task automatic t_match_enabled();
        logic [7:0] v;
        wr(0, 8'd5); wr(1, 8'h80);
        pulse(8'd240); peek(v); chk("R3 frame load", v, 8'h40);
        lines(5); peek(v); chk("R4 no early match", v, 8'h40);
        chk("R5 no early irq", {7'b0, irq}, 8'h00);
        pulse(8'd5); peek(v); chk("R4 match", v, 8'hC0);
        chk("R5 irq on", {7'b0, irq}, 8'h01);
        peek(v); chk("R9 debug read keeps", v, 8'hC0);
        chk("R9 irq kept", {7'b0, irq}, 8'h01);
        rd(1, 0, v); chk("R7 read value", v, 8'hC0);
        peek(v); chk("R7 pending cleared", v, 8'h40);
        chk("R7 irq dropped", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(1, 8'h7F); wr(0, 8'd3);
        pulse(8'd240); lines(4); peek(v);
        chk("R5 pending without enable", v, 8'hC0);
        chk("R5 irq gated", {7'b0, irq}, 8'h00);
        rd(1, 0, v);
    endtask

    task automatic t_write_clears();
        logic [7:0] v;
        wr(0, 8'd2); wr(1, 8'h80);
        pulse(8'd240); lines(3);
        chk("R5 irq set", {7'b0, irq}, 8'h01);
        wr(0, 8'd2); chk("R8 target write drops irq", {7'b0, irq}, 8'h00);
        peek(v); chk("R8 status kept", v, 8'hC0);
        rd(1, 0, v);
        wr(0, 8'd1); pulse(8'd240); lines(2);
        chk("R5 irq set again", {7'b0, irq}, 8'h01);
        wr(1, 8'h80); chk("R8 control write drops irq", {7'b0, irq}, 8'h00);
        rd(1, 0, v);
    endtask

    task automatic t_frame_end();
        logic [7:0] v;
        wr(0, 8'd100); wr(1, 8'h80);
        pulse(8'd240); lines(101);
        chk("R4 match at 100", {7'b0, irq}, 8'h01);
        rd(1, 0, v); chk("R7 read at 100", v, 8'hC0);
        for (int i = 101; i < 239; i++) pulse(8'(i));
        peek(v); chk("R6 before end", v, 8'h40);
        pulse(8'd239); peek(v); chk("R6 status cleared", v, 8'h00);
        wr(0, 8'd0); lines(6); peek(v); chk("R6 saturated no match", v, 8'h00);
        chk("R6 no irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_last_line();
        logic [7:0] v;
        wr(0, 8'd239); wr(1, 8'h80);
        pulse(8'd240); lines(240);
        peek(v); chk("R11 status zero", v, 8'h00);
        chk("R11 irq on", {7'b0, irq}, 8'h01);
        wr(1, 8'h80);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        wr(0, 8'd2); wr(1, 8'h80);
        pulse(8'd240); lines(2);
        cyc(1, 8'd2, 1, 0, 1, 0, 8'h00, v);
        chk("R10 read before match", v, 8'h40);
        peek(v); chk("R10 match wins pending", v, 8'hC0);
        chk("R10 match wins irq", {7'b0, irq}, 8'h01);
        rd(1, 0, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_match_enabled();
        t_disabled();
        t_write_clears();
        t_frame_end();
        t_last_line();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule